// File: doc/BRIEF.md
# Integer ALU with Condition Code Update

This block is the execute-stage arithmetic and logic unit of a 32-bit integer pipeline. In a single cycle it forms a result from the first source register value and a second operand. The second operand is either the second register value or a short immediate taken from the instruction. The block holds the four condition flags (zero, negative, overflow, carry) in a small register. The stored carry feeds the carry-chained operations. The flags are rewritten at the clock edge only when the instruction asks for it.

The supported operations are add, add with carry, subtract, subtract with carry, two reversed-operand subtracts, AND, OR, XOR, three shifts and a load-high that places a long immediate in the upper part of the word. Subtraction adds the inverted operand, so the carry flag holds the inverse of the borrow. Register file access and memory operations sit outside the block. The result is combinational from the inputs. The flags appear one clock edge after the instruction that writes them.

Top module: `falu_top`

## Requirements
- R1: When `scc_i` is 0, or the operation code is not in use, the four flags keep their values across the clock edge.
- R2: Operation codes on `op_i`: 0 ADD, 1 ADDC, 2 SUB, 3 SUBC, 4 SUBI, 5 SUBCI, 6 AND, 7 OR, 8 XOR, 9 SLL, 10 SRL, 11 SRA, 12 LDHI. Codes 13 to 15 give a result of 0 and write no flags.
- R3: When `field_i` bit 13 is 1, the second operand is `field_i[12:0]` sign-extended to 32 bits. Otherwise the second operand is `rs2_i`.
- R4: ADD gives s1+s2 and ADDC gives s1+s2+C, where C is the stored carry flag. When flags are written, C becomes the carry out of bit 31.
- R5: SUB gives s1+NOT(s2)+1 and SUBC gives s1+NOT(s2)+C. When flags are written, C becomes 1 exactly when no borrow occurred.
- R6: SUBI gives s2-s1 and SUBCI gives s2-s1-NOT(C). The carry flag follows the same no-borrow rule as R5.
- R7: For the six arithmetic operations, V is written as 1 exactly when the 32-bit two's-complement result overflows.
- R8: For every operation code in use, Z is written as (result == 0) and N as result bit 31.
- R9: For the logic operations, the shifts and LDHI, V and C are written as 0.
- R10: The shift amount is the low 5 bits of the second operand. SLL and SRL fill with zeros. SRA fills with bit 31 of s1.
- R11: LDHI places `field_i[18:0]` in result bits 31..13 and zeros in bits 12..0.
- R12: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_i | input | 4 | Operation code |
| scc_i | input | 1 | Write the flags for this instruction |
| rs1_i | input | 32 | First source value |
| rs2_i | input | 32 | Second source register value |
| field_i | input | 19 | Low instruction bits: immediate select, short and long immediates |
| result_o | output | 32 | Operation result |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag, inverse of borrow after subtracts |

## Verification
Directed patterns target the edges of the carry and overflow logic:
- adding across the signed maximum, which must set V without C;
- adding all-ones plus one, which must set C and Z;
- subtracting equal values, which must leave C set because no borrow occurs;
- carry-chained subtracts run both with the stored carry clear and with it set, to separate SUBC from SUB.

Shift patterns use amounts whose upper bits are set, which shows that only the low five bits count. They also use negative operands, which separates SRA from SRL. Instructions with `scc_i` low and unused operation codes follow flag-setting instructions, so that a wrong flag write shows up as a change. A long run of random operations with both register and immediate operands is then compared against the reference model on every cycle.

// File: rtl/falu_pkg.sv
package falu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDC  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBC  = 4'd3,
      OP_SUBI  = 4'd4,
      OP_SUBCI = 4'd5,
      OP_AND   = 4'd6,
      OP_OR    = 4'd7,
      OP_XOR   = 4'd8,
      OP_SLL   = 4'd9,
      OP_SRL   = 4'd10,
      OP_SRA   = 4'd11,
      OP_LDHI  = 4'd12
   } falu_op_e;

   function automatic logic op_is_arith(input logic [3:0] op);
      return op <= 4'(OP_SUBCI);
   endfunction

   function automatic logic op_in_use(input logic [3:0] op);
      return op <= 4'(OP_LDHI);
   endfunction

endpackage

// File: rtl/falu_opsel.sv
module falu_opsel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 13
) (
   input  logic              imm_sel_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [DATA_W-1:0] reg_i,
   output logic [DATA_W-1:0] operand_o
);
   localparam int EXT_W = DATA_W - IMM_W;

   initial begin
      assert (IMM_W > 0 && IMM_W < DATA_W)
         else $error("falu_opsel: IMM_W must be between 1 and DATA_W-1");
   end

   always_comb begin
      if (imm_sel_i)
         operand_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      else
         operand_o = reg_i;
   end
endmodule

// File: rtl/falu_addsub.sv
module falu_addsub
   import falu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  falu_op_e          op_i,
   input  logic [DATA_W-1:0] s1_i,
   input  logic [DATA_W-1:0] s2_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o,
   output logic              ovf_o
);
   localparam int MSB = DATA_W - 1;

   logic              swap, invert, carry_in;
   logic [DATA_W-1:0] x, y, y_eff;
   logic [DATA_W:0]   wide;

   always_comb begin
      swap     = (op_i == OP_SUBI) || (op_i == OP_SUBCI);
      invert   = (op_i != OP_ADD) && (op_i != OP_ADDC);
      unique case (op_i)
         OP_ADD:                     carry_in = 1'b0;
         OP_SUB, OP_SUBI:            carry_in = 1'b1;
         default:                    carry_in = cin_i;
      endcase
      x     = swap ? s2_i : s1_i;
      y     = swap ? s1_i : s2_i;
      y_eff = invert ? ~y : y;
      wide  = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, carry_in};
      sum_o  = wide[DATA_W-1:0];
      cout_o = wide[DATA_W];
      ovf_o  = (x[MSB] == y_eff[MSB]) && (sum_o[MSB] != x[MSB]);
   end
endmodule

// File: rtl/falu_logic.sv
module falu_logic
   import falu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 13,
   parameter int LIMM_W    = 19,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  falu_op_e          op_i,
   input  logic [DATA_W-1:0] s1_i,
   input  logic [DATA_W-1:0] s2_i,
   input  logic [LIMM_W-1:0] limm_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int SHW = $clog2(DATA_W);
   localparam int MSB = DATA_W - 1;

   initial begin
      assert (LIMM_W + IMM_W == DATA_W)
         else $error("falu_logic: LIMM_W + IMM_W must equal DATA_W");
      assert ((1 << SHW) == DATA_W)
         else $error("falu_logic: DATA_W must be a power of two");
   end

   logic [SHW-1:0]    amt;
   logic [DATA_W-1:0] shifted;

   assign amt = s2_i[SHW-1:0];

   generate
      if (LOG_SHIFT) begin : g_log_shift
         // Staged right shifter; left shifts run through it bit-reversed.
         logic [DATA_W-1:0] src, rev_src, rev_out;
         logic [DATA_W-1:0] stage [0:SHW];
         logic              fill, left;

         assign left = (op_i == OP_SLL);
         assign fill = (op_i == OP_SRA) && s1_i[MSB];

         for (genvar b = 0; b < DATA_W; b++) begin : g_rev
            assign rev_src[b]       = s1_i[MSB-b];
            assign rev_out[b]       = stage[SHW][MSB-b];
         end

         assign src      = left ? rev_src : s1_i;
         assign stage[0] = src;

         for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amt[k]
               ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]}
               : stage[k];
         end

         assign shifted = left ? rev_out : stage[SHW];
      end else begin : g_op_shift
         always_comb begin
            unique case (op_i)
               OP_SLL:  shifted = s1_i << amt;
               OP_SRA:  shifted = DATA_W'($signed(s1_i) >>> amt);
               default: shifted = s1_i >> amt;
            endcase
         end
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_AND:                 res_o = s1_i & s2_i;
         OP_OR:                  res_o = s1_i | s2_i;
         OP_XOR:                 res_o = s1_i ^ s2_i;
         OP_SLL, OP_SRL, OP_SRA: res_o = shifted;
         OP_LDHI:                res_o = {limm_i, {IMM_W{1'b0}}};
         default:                res_o = '0;
      endcase
   end
endmodule

// File: rtl/falu_top.sv
module falu_top
   import falu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 13,
   parameter int LIMM_W    = 19,
   parameter int SEL_BIT   = 13,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic              scc_i,
   input  logic [DATA_W-1:0] rs1_i,
   input  logic [DATA_W-1:0] rs2_i,
   input  logic [LIMM_W-1:0] field_i,
   output logic [DATA_W-1:0] result_o,
   output logic              z_o,
   output logic              n_o,
   output logic              v_o,
   output logic              c_o
);
   localparam int MSB = DATA_W - 1;

   initial begin
      assert (SEL_BIT >= IMM_W && SEL_BIT < LIMM_W)
         else $error("falu_top: SEL_BIT must lie above the short immediate");
   end

   falu_op_e          op;
   logic [DATA_W-1:0] s2, arith_res, logic_res;
   logic              arith_cout, arith_ovf, arith, in_use, flag_we;

   assign op     = falu_op_e'(op_i);
   assign arith  = op_is_arith(op_i);
   assign in_use = op_in_use(op_i);

   falu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .imm_sel_i (field_i[SEL_BIT]),
      .imm_i     (field_i[IMM_W-1:0]),
      .reg_i     (rs2_i),
      .operand_o (s2)
   );

   falu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .op_i   (op),
      .s1_i   (rs1_i),
      .s2_i   (s2),
      .cin_i  (c_o),
      .sum_o  (arith_res),
      .cout_o (arith_cout),
      .ovf_o  (arith_ovf)
   );

   falu_logic #(
      .DATA_W(DATA_W), .IMM_W(IMM_W), .LIMM_W(LIMM_W), .LOG_SHIFT(LOG_SHIFT)
   ) u_logic (
      .op_i   (op),
      .s1_i   (rs1_i),
      .s2_i   (s2),
      .limm_i (field_i),
      .res_o  (logic_res)
   );

   assign result_o = arith ? arith_res : logic_res;
   assign flag_we  = scc_i && in_use;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_o <= 1'b0;
         n_o <= 1'b0;
         v_o <= 1'b0;
         c_o <= 1'b0;
      end else if (flag_we) begin
         z_o <= (result_o == '0);
         n_o <= result_o[MSB];
         v_o <= arith && arith_ovf;
         c_o <= arith && arith_cout;
      end
   end

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(scc_i && in_use) |=> $stable({z_o, n_o, v_o, c_o})); // R1

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !in_use |-> result_o == '0); // R2

   AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (scc_i && op == OP_SUB) |=> c_o == ($past(rs1_i) >= $past(s2))); // R5

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (scc_i && in_use) |=> z_o == ($past(result_o) == '0)); // R8

   AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (!rst_n)
      (scc_i && in_use && !arith) |=> (!v_o && !c_o)); // R9

   AST_LDHI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LDHI) |-> result_o[IMM_W-1:0] == '0); // R11
endmodule

// File: tb/falu_top_tb_top.sv
module falu_top_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic        scc_i = 1'b0;
   logic [31:0] rs1_i = '0, rs2_i = '0;
   logic [18:0] field_i = '0;
   logic [31:0] result_o;
   logic        z_o, n_o, v_o, c_o;

   int n_chk = 0;
   int n_fail = 0;

   // Reference flag state
   logic mz = 1'b0, mn = 1'b0, mv = 1'b0, mc = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   falu_top dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .scc_i(scc_i),
      .rs1_i(rs1_i), .rs2_i(rs2_i), .field_i(field_i),
      .result_o(result_o), .z_o(z_o), .n_o(n_o), .v_o(v_o), .c_o(c_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Behavioural reference for one instruction
   task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [18:0] f, output logic [31:0] r,
                        output logic cy, output logic ov);
      longint ua = longint'(a), ub = longint'(b);
      longint sa = longint'($signed(a)), sb = longint'($signed(b));
      longint bw = (mc ? 0 : 1);
      longint sr = 0;
      int     sh = int'(b[4:0]);
      cy = 1'b0; ov = 1'b0; r = '0;
      case (op)
         0: begin r = 32'(ua + ub); cy = (ua + ub) > 64'hFFFFFFFF; sr = sa + sb; end
         1: begin r = 32'(ua + ub + (1 - bw)); cy = (ua + ub + (1 - bw)) > 64'hFFFFFFFF;
                  sr = sa + sb + (1 - bw); end
         2: begin r = 32'(ua - ub); cy = ua >= ub; sr = sa - sb; end
         3: begin r = 32'(ua - ub - bw); cy = ua >= ub + bw; sr = sa - sb - bw; end
         4: begin r = 32'(ub - ua); cy = ub >= ua; sr = sb - sa; end
         5: begin r = 32'(ub - ua - bw); cy = ub >= ua + bw; sr = sb - sa - bw; end
         6: r = a & b;
         7: r = a | b;
         8: r = a ^ b;
         9: r = a << sh;
         10: r = a >> sh;
         11: r = 32'($signed(a) >>> sh);
         12: r = {f, 13'd0};
         default: r = '0;
      endcase
      if (op <= 5) ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
   endtask

   task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] rb,
                       input logic [18:0] f, input logic s);
      logic [31:0] b, r;
      logic        cy, ov;
      string       rtag, ftag;
      b = f[13] ? {{19{f[12]}}, f[12:0]} : rb;
      @(negedge clk);
      op_i = op; rs1_i = a; rs2_i = rb; field_i = f; scc_i = s;
      #1;
      model(op, a, b, f, r, cy, ov);
      if (op > 12)       rtag = "R2";
      else if (f[13])    rtag = "R3";
      else if (op <= 1)  rtag = "R4";
      else if (op <= 3)  rtag = "R5";
      else if (op <= 5)  rtag = "R6";
      else if (op <= 8)  rtag = "R9";
      else if (op <= 11) rtag = "R10";
      else               rtag = "R11";
      chk({rtag, " result"}, result_o, r);
      @(posedge clk);
      if (s && op <= 12) begin
         mz = (r == 0); mn = r[31];
         mv = (op <= 5) ? ov : 1'b0;
         mc = (op <= 5) ? cy : 1'b0;
         ftag = (op <= 5) ? "R4 R5 R6 R7 R8 flags" : "R8 R9 flags";
      end else begin
         ftag = "R1 flags";
      end
      #2;
      chk(ftag, {28'd0, z_o, n_o, v_o, c_o}, {28'd0, mz, mn, mv, mc});
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R12 reset flags", {28'd0, z_o, n_o, v_o, c_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 R7: signed overflow without carry, then carry with zero
      step(4'd0, 32'h7FFFFFFF, 32'h1, 19'd0, 1'b1);
      step(4'd0, 32'hFFFFFFFF, 32'h1, 19'd0, 1'b1);
      // R4: ADDC consumes the stored carry
      step(4'd1, 32'h10, 32'h20, 19'd0, 1'b1);
      // R5: equal values, no borrow, C=1 Z=1
      step(4'd2, 32'h1234, 32'h1234, 19'd0, 1'b1);
      // R5: SUBC with C set and then with C cleared
      step(4'd3, 32'h5, 32'h3, 19'd0, 1'b1);
      step(4'd0, 32'h1, 32'h1, 19'd0, 1'b1);
      step(4'd3, 32'h5, 32'h3, 19'd0, 1'b1);
      step(4'd2, 32'h1, 32'h2, 19'd0, 1'b1);
      // R6: reversed subtracts
      step(4'd4, 32'h3, 32'h10, 19'd0, 1'b1);
      step(4'd5, 32'h3, 32'h10, 19'd0, 1'b1);
      step(4'd2, 32'h80000000, 32'h1, 19'd0, 1'b1);
      // R3: negative and positive immediates
      step(4'd0, 32'h100, 32'hDEADBEEF, {5'd0, 1'b1, 13'h1FFF}, 1'b1);
      step(4'd0, 32'h100, 32'hDEADBEEF, {5'd0, 1'b1, 13'h0FFF}, 1'b1);
      // R9: logic ops clear V and C after they were set
      step(4'd0, 32'hFFFFFFFF, 32'h80000000, 19'd0, 1'b1);
      step(4'd6, 32'hF0F0F0F0, 32'h0F0F0F0F, 19'd0, 1'b1);
      // R10: shift amount uses only low 5 bits; SRA vs SRL
      step(4'd9, 32'h1, 32'h3F, 19'd0, 1'b1);
      step(4'd10, 32'h80000000, 32'h21, 19'd0, 1'b1);
      step(4'd11, 32'h80000000, 32'h21, 19'd0, 1'b1);
      step(4'd11, 32'h80000000, 32'h1F, 19'd0, 1'b1);
      // R11: load high
      step(4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 19'h7ABCD, 1'b1);
      // R1: no SCC and unused codes leave flags
      step(4'd0, 32'hFFFFFFFF, 32'h1, 19'd0, 1'b1);
      step(4'd6, 32'h1, 32'h1, 19'd0, 1'b0);
      step(4'd14, 32'h0, 32'h0, 19'd0, 1'b1);
      step(4'd13, 32'h5, 32'h7, 19'd0, 1'b1);
      step(4'd15, 32'h5, 32'h7, 19'd0, 1'b0);

      // Random sweep over all codes and both operand sources
      for (int i = 0; i < 600; i++) begin
         step(4'($urandom_range(0, 15)), $urandom(), $urandom(),
              19'($urandom()), 1'($urandom()));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule